// File: doc/BRIEF.md
# Sticky Mantissa Product Normaliser

This block forms the product half of a single-precision fused multiply-add. It takes two 24-bit significands, each with its leading one present, along with their unbiased exponents and signs. A negate control flips the product sign, which turns the operation into a multiply-subtract. The result is a sign, an exponent and a 27-bit significand: 24 significant bits followed by guard, round and sticky.

Each significand is left-justified in a 32-bit word, and the two words are multiplied. Only the upper 32 bits of the 64-bit product are kept. Any nonzero bit in the lower word is folded into bit 0 of the kept word. That word is then shifted right with sticky collection, by five places when its top bit is set and by four places otherwise, so the leading one always ends up at bit 26. The exponent is bumped in the five-place case.

The multiply is built from four 16x16 partial products with explicit carry from the low word into the high word. A parameter selects one of two builds: one partial product per cycle, or all four in a single cycle. A start/done handshake brackets each operation. When the addend of the multiply-add is zero, this output is already the value that goes to rounding. Addend alignment and rounding belong to neighbouring blocks.

Top module: `fp_prod_norm`

## Requirements
- R1: The result exponent is the two's-complement sum of `exp_a` and `exp_b`, sign-extended to 12 bits, plus the normalisation bump of R5.
- R2: `res_sign` equals `sign_a` XOR `sign_b`, inverted again when `negate` was high at the accepted start.
- R3: The result is derived from the product (`mant_a`<<8)·(`mant_b`<<8). Its kept word is bits 63:32 of that product, with bit 0 additionally ORed with the OR of bits 31:0.
- R4: Bit 0 of `res_mant` is the OR of every product bit below the retained 26 significant bits. A nonzero lower product word alone is enough to set it.
- R5: When bit 31 of the kept word is 1, `res_mant` is kept-word bits 31:5 with the sticky OR of bits 4:0, and the exponent is the sum plus 1.
- R6: When bit 31 of the kept word is 0, `res_mant` is kept-word bits 30:4 with the sticky OR of bits 3:0, and the exponent is the sum unchanged.
- R7: Every delivered result has `res_mant` bit 26 set.
- R8: A start sampled while `busy` is low is accepted. `busy` is high from the next cycle until `done` rises. `done` is a one-cycle pulse that rises 5 rising edges after the accepting edge in the sequential build (the default), or 2 edges after it in the single-cycle build.
- R9: A start sampled while `busy` is high is ignored. It changes neither the result being computed nor the number of done pulses.
- R10: After reset `busy`, `done`, `res_sign`, `res_exp` and `res_mant` are all 0. The result outputs change only in the cycle where `done` is high and hold their value otherwise.
- R11: Input contract: at an accepted start, bit 23 of both `mant_a` and `mant_b` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new product; accepted when not busy |
| mant_a | input | 24 | First significand, leading one at bit 23 |
| mant_b | input | 24 | Second significand, leading one at bit 23 |
| exp_a | input | 10 | First unbiased exponent, two's complement |
| exp_b | input | 10 | Second unbiased exponent, two's complement |
| sign_a | input | 1 | First operand sign |
| sign_b | input | 1 | Second operand sign |
| negate | input | 1 | Invert the product sign (multiply-subtract) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| res_sign | output | 1 | Product sign |
| res_exp | output | 12 | Product exponent, two's complement |
| res_mant | output | 27 | 24 significant bits plus guard, round, sticky |

## Verification
The assertions assume the operands are normalised, meaning bit 23 of each significand is 1 at an accepted start. The leading-one placement at bit 26 and the exponent relations depend on that assumption. Every stimulus in the bench forces bit 23 of both significands, including the pseudo-random vectors, which are ORed with that bit before use. The assertions also assume that a start is only honoured while idle. The bench deliberately raises start mid-operation to show that the request is dropped rather than queued.

// File: rtl/fpn_pkg.sv
package fpn_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int NPP    = 4;

  typedef struct packed {
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } dword_t;

  typedef enum logic [1:0] {
    PP_LL = 2'd0,
    PP_LH = 2'd1,
    PP_HL = 2'd2,
    PP_HH = 2'd3
  } pp_sel_e;

  function automatic logic [WORD_W-1:0] half_mul(input logic [HALF_W-1:0] x,
                                                 input logic [HALF_W-1:0] y);
    return WORD_W'(x) * WORD_W'(y);
  endfunction

  // Adds one 16x16 partial product into a split 64-bit accumulator,
  // carrying from the low word into the high word explicitly.
  function automatic dword_t add_pp(input dword_t acc, input pp_sel_e sel,
                                    input logic [WORD_W-1:0] a,
                                    input logic [WORD_W-1:0] b);
    logic [HALF_W-1:0] ah, al, bh, bl;
    logic [WORD_W-1:0] pp;
    logic [WORD_W:0]   lo_sum;
    dword_t            r;
    ah = a[WORD_W-1:HALF_W];
    al = a[HALF_W-1:0];
    bh = b[WORD_W-1:HALF_W];
    bl = b[HALF_W-1:0];
    r  = acc;
    case (sel)
      PP_LL: begin
        pp     = half_mul(al, bl);
        lo_sum = {1'b0, acc.lo} + {1'b0, pp};
        r.lo   = lo_sum[WORD_W-1:0];
        r.hi   = acc.hi + WORD_W'(lo_sum[WORD_W]);
      end
      PP_LH, PP_HL: begin
        pp     = (sel == PP_LH) ? half_mul(al, bh) : half_mul(ah, bl);
        lo_sum = {1'b0, acc.lo} + {1'b0, pp[HALF_W-1:0], {HALF_W{1'b0}}};
        r.lo   = lo_sum[WORD_W-1:0];
        r.hi   = acc.hi + WORD_W'(lo_sum[WORD_W]) + WORD_W'(pp[WORD_W-1:HALF_W]);
      end
      default: begin
        pp   = half_mul(ah, bh);
        r.hi = acc.hi + pp;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fpn_pp_mult.sv
module fpn_pp_mult
  import fpn_pkg::*;
#(
  parameter bit SEQ_MUL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              running,
  output logic              prod_ready,
  output dword_t            prod
);
  localparam int NSTEP  = SEQ_MUL ? NPP : 1;
  localparam int STEP_W = $clog2(NPP);

  logic [WORD_W-1:0] a_q, b_q;
  logic [STEP_W-1:0] step_q;
  dword_t            acc_next;
  logic              last_step;

  assign last_step = running && (int'(step_q) == NSTEP - 1);

  if (SEQ_MUL) begin : g_seq
    always_comb acc_next = add_pp(prod, pp_sel_e'(step_q), a_q, b_q);
  end else begin : g_comb
    always_comb begin
      acc_next = prod;
      for (int i = 0; i < NPP; i++)
        acc_next = add_pp(acc_next, pp_sel_e'(STEP_W'(i)), a_q, b_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      prod_ready <= 1'b0;
      step_q     <= '0;
      a_q        <= '0;
      b_q        <= '0;
      prod       <= '0;
    end else begin
      prod_ready <= 1'b0;
      if (load) begin
        a_q     <= op_a;
        b_q     <= op_b;
        prod    <= '0;
        step_q  <= '0;
        running <= 1'b1;
      end else if (running) begin
        prod   <= acc_next;
        step_q <= step_q + STEP_W'(1);
        if (last_step) begin
          running    <= 1'b0;
          prod_ready <= 1'b1;
        end
      end
    end
  end

  // R8
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (int'(step_q) < NSTEP));
  // R9
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!running && !prod_ready));
  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prod_ready |=> !prod_ready);
endmodule

// File: rtl/fpn_sticky_norm.sv
module fpn_sticky_norm
  import fpn_pkg::*;
#(
  parameter int RES_W  = 27,
  parameter int OEXP_W = 12
) (
  input  dword_t            prod,
  input  logic [OEXP_W-1:0] exp_in,
  output logic [RES_W-1:0]  mant,
  output logic [OEXP_W-1:0] exp_out,
  output logic              msb_hit,
  output logic              lo_nz
);
  localparam int SH_WIDE   = WORD_W - RES_W;
  localparam int SH_NARROW = SH_WIDE - 1;

  function automatic logic [RES_W-1:0] sticky_shr(input logic [WORD_W-1:0] w,
                                                  input int sh);
    logic [WORD_W-1:0] s;
    logic [WORD_W-1:0] mask;
    mask = ~({WORD_W{1'b1}} << sh);
    s    = w >> sh;
    s[0] = s[0] | (|(w & mask));
    return s[RES_W-1:0];
  endfunction

  logic [WORD_W-1:0] kept;

  assign lo_nz   = |prod.lo;
  assign kept    = prod.hi | WORD_W'(lo_nz);
  assign msb_hit = kept[WORD_W-1];
  assign mant    = msb_hit ? sticky_shr(kept, SH_WIDE) : sticky_shr(kept, SH_NARROW);
  assign exp_out = exp_in + OEXP_W'(msb_hit);
endmodule

// File: rtl/fp_prod_norm.sv
module fp_prod_norm
  import fpn_pkg::*;
#(
  parameter int MANT_W  = 24,
  parameter int EXP_W   = 10,
  parameter bit SEQ_MUL = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [MANT_W-1:0]   mant_a,
  input  logic [MANT_W-1:0]   mant_b,
  input  logic [EXP_W-1:0]    exp_a,
  input  logic [EXP_W-1:0]    exp_b,
  input  logic                sign_a,
  input  logic                sign_b,
  input  logic                negate,
  output logic                busy,
  output logic                done,
  output logic                res_sign,
  output logic [EXP_W+1:0]    res_exp,
  output logic [MANT_W+2:0]   res_mant
);
  localparam int RES_W    = MANT_W + 3;
  localparam int OEXP_W   = EXP_W + 2;
  localparam int ALIGN_SH = WORD_W - MANT_W;

  logic              mul_running, mul_ready, accept;
  logic [WORD_W-1:0] a_al, b_al;
  dword_t            prod;
  logic [OEXP_W-1:0] exp_sum, exp_sum_q, norm_exp;
  logic              sign_q;
  logic [RES_W-1:0]  norm_mant;
  logic              norm_msb_hit, norm_lo_nz;

  assign busy    = mul_running | mul_ready;
  assign accept  = start & ~busy;
  assign a_al    = WORD_W'(mant_a) << ALIGN_SH;
  assign b_al    = WORD_W'(mant_b) << ALIGN_SH;
  assign exp_sum = {{2{exp_a[EXP_W-1]}}, exp_a} + {{2{exp_b[EXP_W-1]}}, exp_b};

  fpn_pp_mult #(.SEQ_MUL(SEQ_MUL)) mult_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .op_a       (a_al),
    .op_b       (b_al),
    .running    (mul_running),
    .prod_ready (mul_ready),
    .prod       (prod)
  );

  fpn_sticky_norm #(.RES_W(RES_W), .OEXP_W(OEXP_W)) norm_i (
    .prod    (prod),
    .exp_in  (exp_sum_q),
    .mant    (norm_mant),
    .exp_out (norm_exp),
    .msb_hit (norm_msb_hit),
    .lo_nz   (norm_lo_nz)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_sum_q <= '0;
      sign_q    <= 1'b0;
    end else if (accept) begin
      exp_sum_q <= exp_sum;
      sign_q    <= sign_a ^ sign_b ^ negate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      res_sign <= 1'b0;
      res_exp  <= '0;
      res_mant <= '0;
    end else begin
      done <= mul_ready;
      if (mul_ready) begin
        res_sign <= sign_q;
        res_exp  <= norm_exp;
        res_mant <= norm_mant;
      end
    end
  end

  // R11
  in_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (mant_a[MANT_W-1] && mant_b[MANT_W-1]));
  // R7
  mant_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_mant[RES_W-1]);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(exp_sum_q) && $stable(sign_q)));
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_mant) && $stable(res_exp) && $stable(res_sign)));
  // R4
  lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_ready && norm_lo_nz) |=> res_mant[0]);
  // R5
  bump_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_ready && norm_msb_hit) |=> (res_exp == exp_sum_q + OEXP_W'(1)));
  // R6
  keep_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_ready && !norm_msb_hit) |=> (res_exp == exp_sum_q));
  // R2
  sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_sign == sign_q));
endmodule

// File: tb/fp_prod_norm_tb_top.sv
module fp_prod_norm_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] mant_a = '0, mant_b = '0;
  logic [9:0]  exp_a = '0, exp_b = '0;
  logic        sign_a = 1'b0, sign_b = 1'b0, negate = 1'b0;
  logic        busy, done, res_sign;
  logic [11:0] res_exp;
  logic [26:0] res_mant;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #5 clk = ~clk;

  fp_prod_norm dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mant_a(mant_a), .mant_b(mant_b), .exp_a(exp_a), .exp_b(exp_b),
    .sign_a(sign_a), .sign_b(sign_b), .negate(negate),
    .busy(busy), .done(done), .res_sign(res_sign),
    .res_exp(res_exp), .res_mant(res_mant)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Independent model on the plain 48-bit product of the significands.
  task automatic model(input logic [23:0] a, input logic [23:0] b,
                       input logic [9:0] ea, input logic [9:0] eb,
                       output logic [26:0] m, output logic [11:0] e);
    logic [47:0] p;
    p = {24'b0, a} * {24'b0, b};
    if (p[47]) m = p[47:21] | {26'b0, |p[20:0]};
    else       m = p[46:20] | {26'b0, |p[19:0]};
    e = {{2{ea[9]}}, ea} + {{2{eb[9]}}, eb} + {11'b0, p[47]};
  endtask

  task automatic issue(input logic [23:0] a, input logic [23:0] b,
                       input logic [9:0] ea, input logic [9:0] eb,
                       input logic sa, input logic sb, input logic ng);
    @(negedge clk);
    mant_a = a; mant_b = b; exp_a = ea; exp_b = eb;
    sign_a = sa; sign_b = sb; negate = ng; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 50) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_op(input logic [23:0] a, input logic [23:0] b,
                        input logic [9:0] ea, input logic [9:0] eb,
                        input logic sa, input logic sb, input logic ng,
                        input string tag);
    logic [26:0] em;
    logic [11:0] ee;
    int n;
    model(a, b, ea, eb, em, ee);
    issue(a, b, ea, eb, sa, sb, ng);
    chk(busy == 1'b1, {tag, " R8 busy after accept"}, 64'(busy), 64'd1);
    wait_done(n);
    chk(n == 5, {tag, " R8 latency"}, 64'(n), 64'd5);
    chk(res_mant == em, {tag, " R3 R4 mantissa"}, 64'(res_mant), 64'(em));
    chk(res_exp == ee, {tag, " R1 R5 R6 exponent"}, 64'(res_exp), 64'(ee));
    chk(res_sign == (sa ^ sb ^ ng), {tag, " R2 sign"}, 64'(res_sign), 64'(sa ^ sb ^ ng));
    chk(res_mant[26] == 1'b1, {tag, " R7 leading one"}, 64'(res_mant[26]), 64'd1);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R8 done one cycle"}, 64'(done), 64'd0);
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R10 reset busy", 64'(busy), 64'd0);
    chk(done == 1'b0, "R10 reset done", 64'(done), 64'd0);
    chk(res_mant == '0, "R10 reset mant", 64'(res_mant), 64'd0);
    chk(res_exp == '0, "R10 reset exp", 64'(res_exp), 64'd0);
    chk(res_sign == 1'b0, "R10 reset sign", 64'(res_sign), 64'd0);
  endtask

  task automatic t_unit;
    run_op(24'h800000, 24'h800000, 10'd3, 10'd4, 1'b0, 1'b0, 1'b0, "unit R6");
    chk(res_mant == 27'h4000000, "R6 one times one", 64'(res_mant), 64'h4000000);
    run_op(24'hC00000, 24'hC00000, 10'd0, 10'd0, 1'b0, 1'b0, 1'b0, "R5 1.5sq");
    chk(res_mant == 27'h4800000, "R5 shift five", 64'(res_mant), 64'h4800000);
    chk(res_exp == 12'd1, "R5 bump", 64'(res_exp), 64'd1);
  endtask

  task automatic t_sticky;
    run_op(24'h800001, 24'h800001, 10'd0, 10'd0, 1'b0, 1'b0, 1'b0, "R4 low word");
    chk(res_mant == 27'h4000011, "R4 sticky from low word", 64'(res_mant), 64'h4000011);
    run_op(24'hFFFFFF, 24'hFFFFFF, 10'd0, 10'd0, 1'b0, 1'b0, 1'b0, "R5 max");
    chk(res_mant == 27'h7FFFFF1, "R5 max sticky", 64'(res_mant), 64'h7FFFFF1);
  endtask

  task automatic t_signs;
    for (int i = 0; i < 8; i++)
      run_op(24'hA5A5A5, 24'h9C3F01, 10'd5, 10'h3F0, i[0], i[1], i[2], "R2 combo");
  endtask

  task automatic t_exp_bounds;
    run_op(24'h800000, 24'h800000, 10'h200, 10'h200, 1'b0, 1'b0, 1'b0, "R1 min");
    chk(res_exp == 12'hC00, "R1 minimum sum", 64'(res_exp), 64'hC00);
    run_op(24'hFFFFFF, 24'hFFFFFF, 10'h1FF, 10'h1FF, 1'b1, 1'b0, 1'b1, "R1 max");
    chk(res_exp == 12'h3FF, "R1 R5 maximum sum", 64'(res_exp), 64'h3FF);
  endtask

  task automatic t_random;
    logic [23:0] a, b;
    logic [9:0] ea, eb;
    for (int i = 0; i < 40; i++) begin
      rng = next_rng(rng); a  = rng[23:0] | 24'h800000; ea = rng[31:22];
      rng = next_rng(rng); b  = rng[23:0] | 24'h800000; eb = rng[31:22];
      run_op(a, b, ea, eb, rng[0], rng[1], rng[2], "R3 random");
    end
  endtask

  task automatic t_busy_start;
    logic [26:0] em;
    logic [11:0] ee;
    int n, extra;
    model(24'hB00001, 24'hD00003, 10'd7, 10'd9, em, ee);
    issue(24'hB00001, 24'hD00003, 10'd7, 10'd9, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    mant_a = 24'h800000; mant_b = 24'h800000; exp_a = 10'd100; exp_b = 10'd100;
    sign_a = 1'b0; negate = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    chk(n == 3, "R9 latency kept", 64'(n), 64'd3);
    chk(res_mant == em, "R9 mantissa of first op", 64'(res_mant), 64'(em));
    chk(res_exp == ee, "R9 exponent of first op", 64'(res_exp), 64'(ee));
    chk(res_sign == 1'b1, "R9 sign of first op", 64'(res_sign), 64'd1);
    extra = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0, "R9 no second done", 64'(extra), 64'd0);
  endtask

  task automatic t_hold;
    logic [26:0] m0;
    logic [11:0] e0;
    logic s0;
    run_op(24'hE12345, 24'h8F0F0F, 10'd12, 10'h3FE, 1'b0, 1'b1, 1'b0, "R10 base");
    m0 = res_mant; e0 = res_exp; s0 = res_sign;
    mant_a = 24'h812345; exp_a = 10'd50; sign_a = 1'b1; negate = 1'b1;
    repeat (6) @(negedge clk);
    chk(res_mant == m0, "R10 mant held", 64'(res_mant), 64'(m0));
    chk(res_exp == e0, "R10 exp held", 64'(res_exp), 64'(e0));
    chk(res_sign == s0, "R10 sign held", 64'(res_sign), 64'(s0));
    chk(busy == 1'b0, "R10 idle without start", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_unit;
    t_sticky;
    t_signs;
    t_exp_bounds;
    t_random;
    t_busy_start;
    t_hold;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule